// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a quad-bank synchronous mobile DRAM from power-on to a usable state. While supply and clock are not yet reported stable it keeps the command bus at NOP and clock-enable low. Once the power-stable input is seen high it holds NOP for a parameterized start-up interval, sized in clock cycles to cover at least 200 µs. It then issues, in a fixed order, a precharge of every bank, two auto-refresh commands, a standard mode-register load and an extended mode-register load. The two mode codes are taken from input ports.

Each command occupies exactly one clock cycle. The gap to the next command is set by its own cycle-count parameter: precharge-to-command, refresh-to-command, or mode-load-to-command. When the last gap has run out, a done flag rises and control passes to the normal-operation controller. The data bus is never driven. The sequence only restarts through reset.

Top module: `sdram_init_seq`

## Requirements
- R1: From reset until power-stable is sampled high, the command pins {cs_n,ras_n,cas_n,we_n} read 4'b0111 (NOP), CKE is low, DQM is high and init_done is low.
- R2: The cycle after power-stable is sampled high, CKE goes high, and NOP with DQM high is held for exactly T_STARTUP cycles.
- R3: The first command is precharge-all: pins 4'b0010, address bit 10 high, all other address bits and both bank bits 0. The next command follows exactly T_RP cycles later.
- R4: Two auto-refresh commands are issued: pins 4'b0001, address 0, bank 0. The second follows the first by T_RFC cycles, and the next command follows the second by T_RFC cycles.
- R5: The standard mode load uses pins 4'b0000 with bank bits 2'b00 and the address equal to mode_code_i. The next command follows T_MRD cycles later.
- R6: The extended mode load uses pins 4'b0000 with bank bits 2'b10 (ba_o[1]=1, ba_o[0]=0) and the address equal to ext_code_i. init_done rises T_MRD cycles later.
- R7: Every command lasts one cycle. Every other cycle carries NOP with address and bank bits at 0.
- R8: Once high, init_done stays high until reset. From then on the pins carry NOP, CKE is high and DQM is low.
- R9: The data-bus output enable dq_oe_o is low at all times.
- R10: Asserting rst_ni low at any point immediately returns the outputs to the R1 state. After release, the full sequence runs again.
- R11: Changes on power-stable after it has been sampled high have no effect on the sequence.
- R12: With all timing parameters set to 1, the commands are issued on consecutive cycles and init_done rises in the cycle after the extended load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_stable_i | input | 1 | Supply and clock reported stable |
| mode_code_i | input | ADDR_W | Code placed on address pins for the standard mode load |
| ext_code_i | input | ADDR_W | Code placed on address pins for the extended mode load |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Address pins |
| ba_o | output | BA_W | Bank select pins |
| cke_o | output | 1 | Clock enable |
| dqm_o | output | 1 | Data mask |
| dq_oe_o | output | 1 | Data bus output enable (always low) |
| init_done_o | output | 1 | Initialization complete |

## Verification
Two events can fall in the same cycle: the gap counter expiring and the next command being issued. With every gap parameter at 1 there are no wait cycles, so each command is decoded in the same cycle as the state that ends the previous gap. A second instance built that way runs in lockstep with a slower-timed instance. For both, the bench computes the cycle index of every command from the parameters and compares every pin on every cycle. A reset applied at a random point in the sequence, and random toggling of power-stable after start, check that an abort or a late input change cannot merge with a pending transition.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  typedef enum logic [3:0] {
    ST_PWR, ST_BOOT,
    ST_PRE, ST_WRP,
    ST_REF1, ST_WRF1,
    ST_REF2, ST_WRF2,
    ST_LMR, ST_WMR1,
    ST_LEMR, ST_WMR2,
    ST_DONE
  } step_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_LMR = 4'b0000;
endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == CNT_W'(1));

  p_no_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned BA_W        = 2,
  parameter int unsigned PRE_ALL_BIT = 10
) (
  input  step_e             step_i,
  input  logic [ADDR_W-1:0] mode_code_i,
  input  logic [ADDR_W-1:0] ext_code_i,
  output logic [3:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o
);
  always_comb begin
    cmd_o  = CMD_NOP;
    addr_o = '0;
    ba_o   = '0;
    unique case (step_i)
      ST_PRE: begin
        cmd_o               = CMD_PRE;
        addr_o[PRE_ALL_BIT] = 1'b1;
      end
      ST_REF1, ST_REF2: cmd_o = CMD_REF;
      ST_LMR: begin
        cmd_o  = CMD_LMR;
        addr_o = mode_code_i;
      end
      ST_LEMR: begin
        cmd_o   = CMD_LMR;
        addr_o  = ext_code_i;
        ba_o[1] = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned BA_W        = 2,
  parameter int unsigned PRE_ALL_BIT = 10,
  parameter int unsigned T_STARTUP   = 10000,
  parameter int unsigned T_RP        = 3,
  parameter int unsigned T_RFC       = 7,
  parameter int unsigned T_MRD       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_stable_i,
  input  logic [ADDR_W-1:0] mode_code_i,
  input  logic [ADDR_W-1:0] ext_code_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              cke_o,
  output logic              dqm_o,
  output logic              dq_oe_o,
  output logic              init_done_o
);
  localparam int unsigned T_GAP_MAX = (T_RP > T_RFC) ? ((T_RP > T_MRD) ? T_RP : T_MRD)
                                                     : ((T_RFC > T_MRD) ? T_RFC : T_MRD);
  localparam int unsigned T_MAX     = (T_STARTUP > T_GAP_MAX) ? T_STARTUP : T_GAP_MAX;
  localparam int unsigned T_MIN     = (T_RP < T_RFC) ? ((T_RP < T_MRD) ? T_RP : T_MRD)
                                                     : ((T_RFC < T_MRD) ? T_RFC : T_MRD);
  localparam int unsigned CNT_W     = $clog2(T_MAX + 1);

  step_e            state_q, state_d;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expired;
  logic [3:0]       cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PWR;
    else         state_q <= state_d;
  end

  // Command states load gap-1; a gap of 1 skips the wait state entirely.
  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_PWR: if (pwr_stable_i) begin
        state_d  = ST_BOOT;
        load     = 1'b1;
        load_val = CNT_W'(T_STARTUP);
      end
      ST_BOOT: if (expired) state_d = ST_PRE;
      ST_PRE: begin
        load     = 1'b1;
        load_val = CNT_W'(T_RP - 1);
        state_d  = (T_RP > 1) ? ST_WRP : ST_REF1;
      end
      ST_WRP:  if (expired) state_d = ST_REF1;
      ST_REF1: begin
        load     = 1'b1;
        load_val = CNT_W'(T_RFC - 1);
        state_d  = (T_RFC > 1) ? ST_WRF1 : ST_REF2;
      end
      ST_WRF1: if (expired) state_d = ST_REF2;
      ST_REF2: begin
        load     = 1'b1;
        load_val = CNT_W'(T_RFC - 1);
        state_d  = (T_RFC > 1) ? ST_WRF2 : ST_LMR;
      end
      ST_WRF2: if (expired) state_d = ST_LMR;
      ST_LMR: begin
        load     = 1'b1;
        load_val = CNT_W'(T_MRD - 1);
        state_d  = (T_MRD > 1) ? ST_WMR1 : ST_LEMR;
      end
      ST_WMR1: if (expired) state_d = ST_LEMR;
      ST_LEMR: begin
        load     = 1'b1;
        load_val = CNT_W'(T_MRD - 1);
        state_d  = (T_MRD > 1) ? ST_WMR2 : ST_DONE;
      end
      ST_WMR2: if (expired) state_d = ST_DONE;
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_PWR;
    endcase
  end

  sdram_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .expired_o  (expired)
  );

  sdram_init_cmd_enc #(
    .ADDR_W      (ADDR_W),
    .BA_W        (BA_W),
    .PRE_ALL_BIT (PRE_ALL_BIT)
  ) u_enc (
    .step_i      (state_q),
    .mode_code_i (mode_code_i),
    .ext_code_i  (ext_code_i),
    .cmd_o       (cmd),
    .addr_o      (addr_o),
    .ba_o        (ba_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
  assign cke_o       = (state_q != ST_PWR);
  assign init_done_o = (state_q == ST_DONE);
  assign dqm_o       = !init_done_o;
  assign dq_oe_o     = 1'b0;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PWR) |-> (cmd == CMD_NOP && !cke_o && dqm_o && !init_done_o));
  p_boot_nop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BOOT) |-> (cmd == CMD_NOP && cke_o && dqm_o));
  p_pre_all_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_PRE) |-> addr_o[PRE_ALL_BIT]);
  p_one_cycle_cmd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (T_MIN > 1 && cmd != CMD_NOP) |=> (cmd == CMD_NOP));
  p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
  p_done_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> (cmd == CMD_NOP && cke_o && !dqm_o));
  p_lemr_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (T_MRD == 1 && state_q == ST_LEMR) |=> init_done_o);
endmodule

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;
  localparam int AW = 12;
  localparam int TS [2] = '{37, 1};
  localparam int RP [2] = '{3, 1};
  localparam int RF [2] = '{7, 1};
  localparam int MR [2] = '{2, 1};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_ni, pwr;
  logic [AW-1:0] mode, ext;
  logic          cs [2], ras [2], cas [2], we [2], cke [2], dqm [2], oe [2], done [2];
  logic [AW-1:0] addr [2];
  logic [1:0]    ba [2];
  int nchk = 0, nfail = 0;

  sdram_init_seq #(.T_STARTUP(37), .T_RP(3), .T_RFC(7), .T_MRD(2)) u_sdram_init_seq (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_stable_i(pwr), .mode_code_i(mode), .ext_code_i(ext),
    .cs_n_o(cs[0]), .ras_n_o(ras[0]), .cas_n_o(cas[0]), .we_n_o(we[0]), .addr_o(addr[0]),
    .ba_o(ba[0]), .cke_o(cke[0]), .dqm_o(dqm[0]), .dq_oe_o(oe[0]), .init_done_o(done[0]));

  // R12: all gaps of one cycle
  sdram_init_seq #(.T_STARTUP(1), .T_RP(1), .T_RFC(1), .T_MRD(1)) u_sdram_init_seq_fast (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_stable_i(pwr), .mode_code_i(mode), .ext_code_i(ext),
    .cs_n_o(cs[1]), .ras_n_o(ras[1]), .cas_n_o(cas[1]), .we_n_o(we[1]), .addr_o(addr[1]),
    .ba_o(ba[1]), .cke_o(cke[1]), .dqm_o(dqm[1]), .dq_oe_o(oe[1]), .init_done_o(done[1]));

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int pins(int d);
    return {cs[d], ras[d], cas[d], we[d]};
  endfunction

  task automatic chk_idle(string tag);
    for (int d = 0; d < 2; d++) begin
      chk(tag, "cmd", pins(d), 4'b0111);
      chk(tag, "cke", cke[d], 0);
      chk(tag, "dqm", dqm[d], 1);
      chk(tag, "done", done[d], 0);
      chk("R9", "dq_oe", oe[d], 0);
    end
  endtask

  // Expected pins k cycles after power-stable was sampled
  task automatic exp_at(int d, int k, output int c, output int a, output int b,
                        output int dm, output int dn, output string tag);
    int b0 = TS[d] + 1;
    int b1 = b0 + RP[d];
    int b2 = b1 + RF[d];
    int b3 = b2 + RF[d];
    int b4 = b3 + MR[d];
    int b5 = b4 + MR[d];
    c = 4'b0111; a = 0; b = 0; dm = 1; dn = 0; tag = "R7";
    if (k < b0)       tag = "R2";
    else if (k == b0) begin c = 4'b0010; a = 12'h400; tag = "R3"; end
    else if (k == b1 || k == b2) begin c = 4'b0001; tag = "R4"; end
    else if (k == b3) begin c = 4'b0000; a = int'(mode); tag = "R5"; end
    else if (k == b4) begin c = 4'b0000; a = int'(ext); b = 2; tag = "R6"; end
    else if (k >= b5) begin dm = 0; dn = 1; tag = "R8"; end
    if (d == 1 && k <= b5) tag = "R12";
  endtask

  task automatic run(int pre, int abort_at, int kmax);
    for (int i = 0; i < pre; i++) begin
      @(negedge clk);
      chk_idle("R1");
    end
    @(negedge clk);
    pwr = 1'b1;
    for (int k = 1; k <= kmax; k++) begin
      @(negedge clk);
      for (int d = 0; d < 2; d++) begin
        int c, a, b, dm, dn;
        string tag;
        exp_at(d, k, c, a, b, dm, dn, tag);
        chk(tag, "cmd", pins(d), c);
        chk(tag, "addr", int'(addr[d]), a);
        chk(tag, "ba", int'(ba[d]), b);
        chk(tag, "cke", cke[d], 1);
        chk(tag, "dqm", dqm[d], dm);
        chk(tag, "done", done[d], dn);
        chk("R9", "dq_oe", oe[d], 0);
      end
      if (k >= 2) pwr = 1'($urandom); // R11: ignored after start
      if (k == abort_at) break;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk_idle("R10");
    repeat (3) @(negedge clk);
    pwr = 1'b0;
    rst_ni = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h1d5e_ed01));
    rst_ni = 1'b0; pwr = 1'b0; mode = '0; ext = '0;
    #1;
    chk_idle("R1");
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // directed corner codes
    mode = 12'hfff; ext = 12'h000;
    run(2, 0, 80);
    do_reset();
    mode = 12'h000; ext = 12'hfff;
    run(0, 0, 70);
    // random codes, random idle length, one run aborted mid-sequence (R10)
    for (int it = 0; it < 5; it++) begin
      do_reset();
      mode = AW'($urandom);
      ext  = AW'($urandom);
      run(int'($urandom_range(0, 5)), (it == 2) ? int'($urandom_range(5, 55)) : 0, 75);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL R7 watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule